// File: doc/BRIEF.md
# Edge-Counting Up/Down Event Counter

This block is a retentive event counter with one signed accumulator, driven by two rung inputs. One rung counts up and the other counts down. A rung changes the count only when it goes from false to true, so a rung that stays true adds or removes exactly one count. The count holds its value while both rungs are false. It changes again only on a new rising edge or on a reset request.

The accumulator covers the symmetric range from minus LIMIT to plus LIMIT, which is 9999 by default. One step past either end of the range returns the count to zero. A done output compares the count with a signed preset input and is true while the count is at or above the preset. A zero flag marks an empty count. Up and down enable bits show the rung levels one cycle late. A synchronous reset request clears the count and holds both enable bits low for as long as it stays asserted.

The block sits behind the logic that evaluates the rungs. It takes the two rung results each cycle and supplies the status that a control program reads back.

Top module: `ud_event_counter`

## Requirements
- R1: After system reset (rstN low) and before any rung edge, accValue is 0, upEnable and downEnable are 0, and zero is 1.
- R2: A rising edge on upRung (1 now, 0 in the previous cycle) with no edge on downRung raises accValue by one at the next clock edge. A level held high counts once only.
- R3: A rising edge on downRung with no edge on upRung lowers accValue by one at the next clock edge. A level held high counts once only.
- R4: An up step taken with accValue equal to +LIMIT sets accValue to 0. The count never goes above +LIMIT.
- R5: A down step taken with accValue equal to -LIMIT sets accValue to 0. The count never goes below -LIMIT.
- R6: done is 1 exactly when accValue is at or above preset, both compared as two's-complement signed values. done stays 1 while the count rises past the preset and returns to 0 once the count falls below it.
- R7: zero is 1 exactly when accValue equals 0.
- R8: With no rising edge on either rung, accValue keeps its value, including while the rungs are low.
- R9: While countReset is 1, accValue is 0 from the next cycle on and rung edges are ignored. upEnable and downEnable are 0 for every cycle that follows a cycle with countReset high, even if a rung is high. A rung held high through the release of reset does not count afterwards.
- R10: With a negative preset, a reset request that sets accValue to 0 makes done equal to 1.
- R11: Rising edges on both rungs in the same cycle cancel, and accValue is unchanged.
- R12: With countReset low, upEnable and downEnable each equal their rung's level from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low system reset |
| countReset | input | 1 | Synchronous reset request for count and status |
| upRung | input | 1 | Count-up rung result |
| downRung | input | 1 | Count-down rung result |
| preset | input | ACC_W | Signed compare value for done |
| accValue | output | ACC_W | Signed accumulator |
| upEnable | output | 1 | Registered count-up rung level, cleared under reset request |
| downEnable | output | 1 | Registered count-down rung level, cleared under reset request |
| done | output | 1 | Count at or above preset |
| zero | output | 1 | Count equals zero |

## Verification
The bench builds the block with its default values, ACC_W = 16 and LIMIT = 9999. At these values both wrap points can be reached by ten thousand edges in each direction, so the positive and negative limits are covered by a full walk and not by a shrunken range. A 16-bit word also leaves headroom beyond ±9999. Because of that headroom, a missing wrap shows up as 10000 or -10000 and not as a silent two's-complement rollover.

// File: rtl/ud_counter_pkg.sv
package ud_counter_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic clear;   // reset request: force the count to zero
    logic inc;     // net single step upward
    logic dec;     // net single step downward
  } ctrStrobe_t;

  localparam int NUM_RUNGS = 2;
  localparam int RUNG_UP   = 0;
  localparam int RUNG_DOWN = 1;

endpackage

// File: rtl/ud_counter_ctrl.sv
module ud_counter_ctrl
  import ud_counter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       countReset,
  input  logic       upRung,
  input  logic       downRung,
  output ctrStrobe_t strobe,
  output logic       upEnable,
  output logic       downEnable
);

  logic [NUM_RUNGS-1:0] rungNow;
  logic [NUM_RUNGS-1:0] rungPrev;
  logic [NUM_RUNGS-1:0] rungEdge;
  logic [NUM_RUNGS-1:0] rungEnable;

  assign rungNow[RUNG_UP]   = upRung;
  assign rungNow[RUNG_DOWN] = downRung;

  // One edge detector and one enable bit per rung
  for (genvar g = 0; g < NUM_RUNGS; g++) begin : g_rung
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rungPrev[g]   <= 1'b0;
        rungEnable[g] <= 1'b0;
      end else begin
        // the previous level is tracked through reset so that a level
        // held across reset release is not seen as a fresh edge
        rungPrev[g]   <= rungNow[g];
        rungEnable[g] <= rungNow[g] & ~countReset;
      end
    end
    assign rungEdge[g] = rungNow[g] & ~rungPrev[g];
  end

  always_comb begin
    strobe.clear = countReset;
    strobe.inc   = ~countReset & rungEdge[RUNG_UP]   & ~rungEdge[RUNG_DOWN];
    strobe.dec   = ~countReset & rungEdge[RUNG_DOWN] & ~rungEdge[RUNG_UP];
  end

  assign upEnable   = rungEnable[RUNG_UP];
  assign downEnable = rungEnable[RUNG_DOWN];

endmodule

// File: rtl/ud_counter_dp.sv
module ud_counter_dp
  import ud_counter_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int LIMIT = 9999
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrStrobe_t              strobe,
  input  logic signed [ACC_W-1:0] preset,
  output logic signed [ACC_W-1:0] accValue,
  output logic                    done,
  output logic                    zero
);

  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(LIMIT);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM;
  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1);

  logic signed [ACC_W-1:0] accQ;
  logic signed [ACC_W-1:0] accNext;
  logic                    atTop;
  logic                    atBottom;

  assign atTop    = (accQ == POS_LIM);
  assign atBottom = (accQ == NEG_LIM);

  always_comb begin
    accNext = accQ;
    if (strobe.clear) begin
      accNext = '0;
    end else if (strobe.inc) begin
      accNext = atTop ? '0 : accQ + ONE;
    end else if (strobe.dec) begin
      accNext = atBottom ? '0 : accQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accQ <= '0;
    else       accQ <= accNext;
  end

  assign accValue = accQ;
  assign done     = (accQ >= preset);
  assign zero     = (accQ == '0);

endmodule

// File: rtl/ud_event_counter.sv
module ud_event_counter
  import ud_counter_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int LIMIT = 9999
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    countReset,
  input  logic                    upRung,
  input  logic                    downRung,
  input  logic signed [ACC_W-1:0] preset,
  output logic signed [ACC_W-1:0] accValue,
  output logic                    upEnable,
  output logic                    downEnable,
  output logic                    done,
  output logic                    zero
);

  ctrStrobe_t strobe;

  ud_counter_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .countReset (countReset),
    .upRung     (upRung),
    .downRung   (downRung),
    .strobe     (strobe),
    .upEnable   (upEnable),
    .downEnable (downEnable)
  );

  ud_counter_dp #(
    .ACC_W (ACC_W),
    .LIMIT (LIMIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .preset   (preset),
    .accValue (accValue),
    .done     (done),
    .zero     (zero)
  );

endmodule

// File: rtl/ud_event_counter_chk.sv
module ud_event_counter_chk #(
  parameter int ACC_W = 16,
  parameter int LIMIT = 9999
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    countReset,
  input logic                    upRung,
  input logic                    downRung,
  input logic signed [ACC_W-1:0] accValue,
  input logic                    upEnable,
  input logic                    downEnable
);

  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(LIMIT);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM;

  logic upSeen;
  logic downSeen;
  logic upRise;
  logic downRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upSeen   <= 1'b0;
      downSeen <= 1'b0;
    end else begin
      upSeen   <= upRung;
      downSeen <= downRung;
    end
  end

  assign upRise   = upRung & ~upSeen;
  assign downRise = downRung & ~downSeen;

  // R4 and R5: the count stays inside the symmetric range
  assert_acc_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accValue <= POS_LIM) && (accValue >= NEG_LIM));

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    countReset |=> (accValue == '0) && !upEnable && !downEnable);

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!countReset && upRise && !downRise && accValue != POS_LIM)
      |=> accValue == ACC_W'($past(accValue) + 1));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!countReset && downRise && !upRise && accValue != NEG_LIM)
      |=> accValue == ACC_W'($past(accValue) - 1));

  assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!countReset && upRise && !downRise && accValue == POS_LIM)
      |=> accValue == '0);

  assert_down_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!countReset && downRise && !upRise && accValue == NEG_LIM)
      |=> accValue == '0);

  // R8, and R11 when both rungs rise together
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!countReset && (upRise == downRise)) |=> $stable(accValue));

  assert_enable_follow_R12: assert property (@(posedge clk) disable iff (!rstN)
    !countReset |=> (upEnable == $past(upRung)) && (downEnable == $past(downRung)));

endmodule

bind ud_event_counter ud_event_counter_chk #(
  .ACC_W (ACC_W),
  .LIMIT (LIMIT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .countReset (countReset),
  .upRung     (upRung),
  .downRung   (downRung),
  .accValue   (accValue),
  .upEnable   (upEnable),
  .downEnable (downEnable)
);

// File: tb/ud_event_counter_bench.sv
module ud_event_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 16;
  localparam int LIMIT      = 9999;
  localparam int MAX_CYCLES = 200000;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    countReset = 1'b0;
  logic                    upRung = 1'b0;
  logic                    downRung = 1'b0;
  logic signed [ACC_W-1:0] preset = '0;
  logic signed [ACC_W-1:0] accValue;
  logic                    upEnable;
  logic                    downEnable;
  logic                    done;
  logic                    zero;

  ud_event_counter #(.ACC_W(ACC_W), .LIMIT(LIMIT)) u_ud_event_counter (
    .clk        (clk),
    .rstN       (rstN),
    .countReset (countReset),
    .upRung     (upRung),
    .downRung   (downRung),
    .preset     (preset),
    .accValue   (accValue),
    .upEnable   (upEnable),
    .downEnable (downEnable),
    .done       (done),
    .zero       (zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    acc;
    bit    done;
    bit    zero;
    bit    upEn;
    bit    dnEn;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  int mAcc = 0;
  bit mPrevUp = 0;
  bit mPrevDn = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected state pushed to the scoreboard
  task automatic step(input bit u, input bit d, input bit r, input int pre, input string tag);
    expItem_t e;
    bit ue, de;
    @(negedge clk);
    upRung = u; downRung = d; countReset = r; preset = ACC_W'(pre);
    ue = u & ~mPrevUp;
    de = d & ~mPrevDn;
    if (r) mAcc = 0;
    else if (ue && !de) mAcc = (mAcc == LIMIT) ? 0 : mAcc + 1;
    else if (de && !ue) mAcc = (mAcc == -LIMIT) ? 0 : mAcc - 1;
    mPrevUp = u; mPrevDn = d;
    e.acc = mAcc;
    e.done = (mAcc >= pre);
    e.zero = (mAcc == 0);
    e.upEn = u & ~r;
    e.dnEn = d & ~r;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic pulseUp(input int pre, input string tag);
    step(1, 0, 0, pre, tag);
    step(0, 0, 0, pre, tag);
  endtask

  task automatic pulseDown(input int pre, input string tag);
    step(0, 1, 0, pre, tag);
    step(0, 0, 0, pre, tag);
  endtask

  // monitor: compare outputs just after each clock edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(e.tag, "accValue", int'(accValue), e.acc);
      check(e.tag, "done", int'(done), int'(e.done));
      check("R7", "zero", int'(zero), int'(e.zero));
      check(e.tag, "upEnable", int'(upEnable), int'(e.upEn));
      check(e.tag, "downEnable", int'(downEnable), int'(e.dnEn));
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: state straight after system reset
    #1;
    check("R1", "accValue", int'(accValue), 0);
    check("R1", "upEnable", int'(upEnable), 0);
    check("R1", "downEnable", int'(downEnable), 0);
    check("R1", "zero", int'(zero), 1);

    // R2 and R12: a level held high counts once and shows as an enable
    step(1, 0, 0, 5, "R2");
    step(1, 0, 0, 5, "R2");
    step(1, 0, 0, 5, "R12");
    step(0, 0, 0, 5, "R12");
    pulseUp(5, "R2");
    // R3: down edges, one held high for several cycles
    step(0, 1, 0, 5, "R3");
    step(0, 1, 0, 5, "R3");
    step(0, 0, 0, 5, "R3");
    pulseDown(5, "R3");
    pulseDown(5, "R3");
    // R6: done rises at the preset, stays above it, clears below it
    for (int i = 0; i < 5; i++) pulseUp(3, "R6");
    for (int i = 0; i < 3; i++) pulseDown(3, "R6");
    // R8: idle cycles keep the count
    for (int i = 0; i < 4; i++) step(0, 0, 0, 3, "R8");
    // R11: both rungs rise in the same cycle
    step(1, 1, 0, 3, "R11");
    step(0, 0, 0, 3, "R11");
    step(1, 0, 0, 3, "R11");
    step(1, 1, 0, 3, "R11");
    step(0, 0, 0, 3, "R11");
    // R9: reset request with rungs high; edges ignored; no count after release
    step(1, 0, 1, 3, "R9");
    step(0, 1, 1, 3, "R9");
    step(1, 1, 1, 3, "R9");
    step(1, 1, 0, 3, "R9");
    step(1, 1, 0, 3, "R9");
    step(0, 0, 0, 3, "R9");
    pulseUp(3, "R9");
    pulseDown(-5, "R10");
    pulseDown(-5, "R10");
    // R10: negative preset, reset sets done
    step(0, 0, 1, -5, "R10");
    step(0, 0, 0, -5, "R10");
    // R4: full walk up to +LIMIT and one step past
    for (int i = 0; i < LIMIT; i++) pulseUp(LIMIT, "R4");
    pulseUp(LIMIT, "R4");
    pulseUp(LIMIT, "R4");
    step(0, 0, 1, 0, "R9");
    // R5: full walk down to -LIMIT and one step past
    for (int i = 0; i < LIMIT; i++) pulseDown(-LIMIT, "R5");
    pulseDown(-LIMIT, "R5");
    pulseDown(-LIMIT, "R5");
    repeat (3) @(negedge clk);
    finish();
  end

endmodule